// File: doc/BRIEF.md
# Multiplexed Bidirectional GPIO Port

This block controls an 8-pin bidirectional general-purpose I/O port whose pins can be handed to other users. Software sees three registers through a small register bus. One register sets each pin's direction, one holds the output values to be driven, and one reads back the level seen at the pins. Writing a 1 to a direction bit makes that pin an input and turns off its driver. Writing a 0 drives the stored output bit onto the pin. Pin levels enter through a two-flop synchronizer before anything inside the block uses them.

An ownership multiplexer sits between the register logic and the pads. It decides for each pin whether the pin is general I/O or belongs to another function. In an external-memory operating mode, the whole port becomes the upper address/data byte of the system bus, unless the bus-disable input is set. In single-chip mode, two other functions can take pins. A slave-port enable turns pins 2:0 into synchronized control inputs. A low alternate-pin configuration bit routes the capture/compare channel 2 output onto pin 7. The choice is decoded combinationally from level inputs, so ownership changes in the same cycle as those inputs. The register bus is a plain strobe interface: a write takes effect on the next rising edge and a read is combinational.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is asserted and right after it, the direction register holds 0xFF and the output latch holds 0x00. In single-chip mode every pad output enable is therefore 0.
- R2: For a pin owned by general I/O, a direction bit of 1 gives `pad_oe`=0, and a direction bit of 0 gives `pad_oe`=1 with `pad_out` equal to the latch bit. Writing 0x03 to the direction register makes pins 1:0 inputs and pins 7:2 outputs.
- R3: A read at address 1 (latch) returns the stored latch value, not the pin levels.
- R4: A read at address 0 (port) returns the pad levels delayed by exactly two rising clock edges.
- R5: A write to address 0 or address 1 updates the output latch. A write to address 2 updates the direction register.
- R6: When `mode_i` is not 2'b00 (01 = microprocessor, 10 = extended single-chip, 11 treated the same) and `bus_dis` is 0, every pin drives `bus_addr_hi` with output enable `bus_oe`. Direction and latch have no effect on the pins in this state.
- R7: With `bus_dis`=1 in an external-memory mode, all pins return to general I/O behaviour.
- R8: In mode 2'b00 with `psp_en`=1, pins 2:0 have `pad_oe`=0 whatever the direction bits hold. `psp_ctrl` carries the synchronized levels of pins 2:0 (bit 0 read strobe, bit 1 write strobe, bit 2 chip select). When the slave port is not active, `psp_ctrl` is 0.
- R9: In mode 2'b00 with `ccp_remap_n`=0, pin 7 drives `ccp_out` with `pad_oe`=1.
- R10: The priority order is system bus, then slave-port controls, then the capture/compare pin, then general I/O. `psp_en` and `ccp_remap_n` have no effect in external-memory modes, including when `bus_dis` is 1.
- R11: When reset is released in mode 2'b10 with `bus_dis`=0, the pins are owned by the system bus.
- R12: A write to address 3 changes neither register, and a read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| mode_i | input | 2 | Operating mode: 00 single-chip, others external memory |
| bus_dis | input | 1 | Releases the pins from the system bus |
| psp_en | input | 1 | Enables slave-port control inputs on pins 2:0 |
| ccp_remap_n | input | 1 | Low routes capture/compare output to pin 7 |
| ccp_out | input | 1 | Capture/compare channel 2 output |
| bus_addr_hi | input | 8 | System bus upper address/data byte to drive |
| bus_oe | input | 1 | System bus output enable |
| bus_rdata | output | 8 | Synchronized pin levels returned to the bus |
| psp_ctrl | output | 3 | Synchronized slave-port controls |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 drives |

## Verification
The assertions assume that `reg_addr` and `reg_wdata` are known whenever `reg_wr` is high. They also assume that mode and configuration inputs are valid, known levels at every rising edge. Under these assumptions the register-update and ownership properties can be stated directly. The stimulus meets this by changing every input only on the falling clock edge and keeping the write strobe low between writes. It changes the mode only around reset or between scenarios.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    MODE_MCU = 2'b00,
    MODE_MPU = 2'b01,
    MODE_EMC = 2'b10,
    MODE_RSV = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    ADDR_PORT = 2'd0,
    ADDR_LAT  = 2'd1,
    ADDR_DIR  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    OWN_GPIO,
    OWN_CCP,
    OWN_PSP,
    OWN_BUS
  } pin_owner_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
      // R4
      sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg[0] == $past(d));
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
      // R4
      sync_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg[i] == $past(stg[i-1]));
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pins_sync,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);
  logic wr_lat, wr_dir;

  assign wr_lat = wr && (addr == ADDR_PORT || addr == ADDR_LAT);
  assign wr_dir = wr && (addr == ADDR_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_lat) lat_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      ADDR_PORT: rdata = pins_sync;
      ADDR_LAT:  rdata = lat_q;
      ADDR_DIR:  rdata = dir_q;
      default:   rdata = '0;
    endcase
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (dir_q == '1 && lat_q == '0));
  // R5
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr && addr == ADDR_DIR) |-> dir_q == $past(wdata));
  // R5
  lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr && (addr == ADDR_PORT || addr == ADDR_LAT))
      |-> lat_q == $past(wdata));
  // R12
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr && addr == ADDR_NONE) |-> ($stable(dir_q) && $stable(lat_q)));
endmodule

// File: rtl/gpio_pin_owner.sv
module gpio_pin_owner
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int PSP_PINS = 3,
  parameter int CCP_PIN  = 7
) (
  input  logic [1:0]       mode,
  input  logic             bus_dis,
  input  logic             psp_en,
  input  logic             ccp_remap_n,
  input  logic             ccp_out,
  input  logic [WIDTH-1:0] bus_addr_hi,
  input  logic             bus_oe,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  output logic             psp_active,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  logic bus_own, single_chip, ccp_active;
  pin_owner_e owner [WIDTH];

  assign single_chip = (mode == MODE_MCU);
  assign bus_own     = !single_chip && !bus_dis;
  assign psp_active  = single_chip && psp_en;
  assign ccp_active  = single_chip && !ccp_remap_n;

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    localparam bit IS_PSP = (p < PSP_PINS);
    localparam bit IS_CCP = (p == CCP_PIN);

    always_comb begin
      if (bus_own)                   owner[p] = OWN_BUS;
      else if (IS_PSP && psp_active) owner[p] = OWN_PSP;
      else if (IS_CCP && ccp_active) owner[p] = OWN_CCP;
      else                           owner[p] = OWN_GPIO;
    end

    always_comb begin
      case (owner[p])
        OWN_BUS: begin pad_out[p] = bus_addr_hi[p]; pad_oe[p] = bus_oe;    end
        OWN_PSP: begin pad_out[p] = 1'b0;           pad_oe[p] = 1'b0;      end
        OWN_CCP: begin pad_out[p] = ccp_out;        pad_oe[p] = 1'b1;      end
        default: begin pad_out[p] = lat_q[p];       pad_oe[p] = !dir_q[p]; end
      endcase
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PSP_PINS    = 3,
  parameter int CCP_PIN     = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [WIDTH-1:0]    reg_wdata,
  output logic [WIDTH-1:0]    reg_rdata,
  input  logic [1:0]          mode_i,
  input  logic                bus_dis,
  input  logic                psp_en,
  input  logic                ccp_remap_n,
  input  logic                ccp_out,
  input  logic [WIDTH-1:0]    bus_addr_hi,
  input  logic                bus_oe,
  output logic [WIDTH-1:0]    bus_rdata,
  output logic [PSP_PINS-1:0] psp_ctrl,
  input  logic [WIDTH-1:0]    pad_in,
  output logic [WIDTH-1:0]    pad_out,
  output logic [WIDTH-1:0]    pad_oe
);
  logic [WIDTH-1:0] pins_sync, dir_q, lat_q;
  logic             psp_active;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .pins_sync(pins_sync), .rdata(reg_rdata),
    .dir_q(dir_q), .lat_q(lat_q)
  );

  gpio_pin_owner #(.WIDTH(WIDTH), .PSP_PINS(PSP_PINS), .CCP_PIN(CCP_PIN)) u_owner (
    .mode(mode_i), .bus_dis(bus_dis), .psp_en(psp_en),
    .ccp_remap_n(ccp_remap_n), .ccp_out(ccp_out),
    .bus_addr_hi(bus_addr_hi), .bus_oe(bus_oe),
    .dir_q(dir_q), .lat_q(lat_q), .psp_active(psp_active),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign bus_rdata = pins_sync;
  assign psp_ctrl  = psp_active ? pins_sync[PSP_PINS-1:0] : '0;

  // R8
  psp_pins_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_MCU && psp_en) |-> pad_oe[PSP_PINS-1:0] == '0);
  // R9
  ccp_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_MCU && !ccp_remap_n) |-> (pad_oe[CCP_PIN] && pad_out[CCP_PIN] == ccp_out));
  // R6
  bus_owns_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_MCU && !bus_dis) |-> (pad_out == bus_addr_hi && pad_oe == {WIDTH{bus_oe}}));
endmodule

// File: tb/tb_gpio_mux_port.sv
`timescale 1ns/1ps
module tb_gpio_mux_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] mode_i = 2'b00;
  logic       bus_dis = 1'b0, psp_en = 1'b0, ccp_remap_n = 1'b1, ccp_out = 1'b0;
  logic [7:0] bus_addr_hi = 8'h00;
  logic       bus_oe = 1'b0;
  logic [7:0] bus_rdata;
  logic [2:0] psp_ctrl;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_mux_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_i(mode_i),
    .bus_dis(bus_dis), .psp_en(psp_en), .ccp_remap_n(ccp_remap_n),
    .ccp_out(ccp_out), .bus_addr_hi(bus_addr_hi), .bus_oe(bus_oe),
    .bus_rdata(bus_rdata), .psp_ctrl(psp_ctrl), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    mode_i = m; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    do_reset(2'b00);
    rd_reg(2'd2, v); check("R1 dir reset", v, 8'hFF);
    rd_reg(2'd1, v); check("R1 latch reset", v, 8'h00);
    check("R1 oe reset", pad_oe, 8'h00);
  endtask

  task automatic t_dir_latch;
    wr_reg(2'd1, 8'hA5);
    wr_reg(2'd2, 8'h03);
    #1;
    check("R2 oe dir 0x03", pad_oe, 8'hFC);
    check("R2 out bits 7:2", pad_out & 8'hFC, 8'hA4);
    wr_reg(2'd2, 8'h00);
    #1;
    check("R2 all outputs", pad_out, 8'hA5);
  endtask

  task automatic t_latch_vs_pin;
    logic [7:0] v;
    pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd_reg(2'd1, v); check("R3 latch not pins", v, 8'hA5);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk);
    pad_in = 8'h96;
    rd_reg(2'd0, v); check("R4 one edge old", v, 8'h3C);
    rd_reg(2'd0, v); check("R4 two edges new", v, 8'h96);
    check("R4 bus_rdata", bus_rdata, 8'h96);
  endtask

  task automatic t_port_write;
    logic [7:0] v;
    wr_reg(2'd0, 8'h5A);
    rd_reg(2'd1, v); check("R5 port write to latch", v, 8'h5A);
    wr_reg(2'd2, 8'h0F);
    rd_reg(2'd2, v); check("R5 dir write", v, 8'h0F);
  endtask

  task automatic t_bus_own;
    @(negedge clk);
    mode_i = 2'b01; bus_dis = 1'b0; bus_addr_hi = 8'hC3; bus_oe = 1'b1;
    #1;
    check("R6 bus out mpu", pad_out, 8'hC3);
    check("R6 bus oe mpu", pad_oe, 8'hFF);
    @(negedge clk);
    mode_i = 2'b11; bus_oe = 1'b0;
    #1;
    check("R6 bus oe mode 11", pad_oe, 8'h00);
  endtask

  task automatic t_bus_disable;
    @(negedge clk);
    mode_i = 2'b10; bus_dis = 1'b1;
    #1;
    check("R7 gpio oe", pad_oe, 8'hF0);
    check("R7 gpio out", pad_out & 8'hF0, 8'h50);
  endtask

  task automatic t_psp;
    logic [7:0] v;
    @(negedge clk);
    mode_i = 2'b00; bus_dis = 1'b0; psp_en = 1'b1;
    wr_reg(2'd2, 8'h00);
    #1;
    check("R8 psp pins input", pad_oe, 8'hF8);
    @(negedge clk);
    pad_in = 8'h05;
    repeat (2) @(negedge clk);
    check("R8 psp ctrl", {5'd0, psp_ctrl}, 8'h05);
    psp_en = 1'b0;
    #1;
    check("R8 psp ctrl idle", {5'd0, psp_ctrl}, 8'h00);
    rd_reg(2'd0, v); check("R8 port read", v, 8'h05);
  endtask

  task automatic t_ccp;
    @(negedge clk);
    wr_reg(2'd2, 8'hFF);
    ccp_remap_n = 1'b0; ccp_out = 1'b1;
    #1;
    check("R9 ccp drives pin7", {pad_oe[7], pad_out[7]}, 8'h03);
    ccp_out = 1'b0;
    #1;
    check("R9 ccp follows", {pad_oe[7], pad_out[7]}, 8'h02);
  endtask

  task automatic t_priority;
    @(negedge clk);
    psp_en = 1'b1; ccp_remap_n = 1'b0; ccp_out = 1'b1;
    wr_reg(2'd2, 8'hFF);
    #1;
    check("R10 psp and ccp together", pad_oe, 8'h80);
    @(negedge clk);
    mode_i = 2'b01; bus_dis = 1'b0; bus_oe = 1'b1; bus_addr_hi = 8'h12;
    #1;
    check("R10 bus over psp/ccp", pad_out, 8'h12);
    check("R10 bus oe", pad_oe, 8'hFF);
    bus_dis = 1'b1;
    #1;
    check("R10 psp/ccp ignored ext mode", pad_oe, 8'h00);
    @(negedge clk);
    psp_en = 1'b0; ccp_remap_n = 1'b1; bus_dis = 1'b0;
  endtask

  task automatic t_emc_reset;
    bus_addr_hi = 8'h7E; bus_oe = 1'b1;
    do_reset(2'b10);
    check("R11 emc reset out", pad_out, 8'h7E);
    check("R11 emc reset oe", pad_oe, 8'hFF);
  endtask

  task automatic t_unused;
    logic [7:0] v;
    do_reset(2'b00);
    wr_reg(2'd1, 8'h33);
    wr_reg(2'd3, 8'hCC);
    rd_reg(2'd1, v); check("R12 latch unchanged", v, 8'h33);
    rd_reg(2'd2, v); check("R12 dir unchanged", v, 8'hFF);
    rd_reg(2'd3, v); check("R12 read zero", v, 8'h00);
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_dir_latch();
    t_latch_vs_pin();
    t_sync();
    t_port_write();
    t_bus_own();
    t_bus_disable();
    t_psp();
    t_ccp();
    t_priority();
    t_emc_reset();
    t_unused();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule